// File: doc/BRIEF.md
# Expanded-Memory Window Translator

This block maps CPU addresses that fall inside a 64 KB page frame in the upper-memory area onto arbitrary 16 KB pages of DRAM. The frame is made of four adjacent 16 KB windows. A two-bit selector places the frame at one of four bases. Each window has its own pair of page registers, which together name the physical 16 KB page that the window shows. A global enable bit turns translation on and off.

For every 24-bit CPU address the block reports whether it hits an enabled window and gives the address to present to DRAM. On a miss the address passes through unchanged. A translated page at or beyond the installed memory size is treated as absent: reads return all ones and writes are suppressed. A hit also overrides any shadow-RAM claim on the same region. Translation is combinational from the address and the held register values. A register write becomes visible from the cycle after it is taken.

Top module: `ems_xlate`

## Requirements
- R1: After reset, translation is disabled and all page fields are zero, so no address hits and `phys_addr` equals `cpu_addr`.
- R2: `win_hit` can be asserted only while the enable bit (bit 3 of the value written at register index 3) is set. Writing that index with bit 3 clear disables translation.
- R3: Bits [1:0] written at register index 12 select the frame base: 0 gives 0xC0000, 1 gives 0xC8000, 2 gives 0xD0000 and 3 gives 0xE0000.
- R4: The frame covers exactly base to base+0xFFFF, below 1 MB. Window n is base+n*0x4000 through base+n*0x4000+0x3FFF. Addresses one below the base, at base+0x10000 and at or above 1 MB do not hit.
- R5: Window n uses the high field at index 4+2n and the low field at index 5+2n. Bits [4:0] of the high field form physical address bits [23:19] and bits [4:0] of the low field form bits [18:14]. Written bits [7:5] have no effect.
- R6: On a hit, `phys_addr[13:0]` equals `cpu_addr[13:0]`.
- R7: On a miss, `phys_addr` equals `cpu_addr`.
- R8: On a hit where `phys_addr[23:14]` is greater than or equal to `mem_pages`, `in_range` is 0, `cpu_rdata` is all ones and `dram_we` is 0.
- R9: In every other case, `cpu_rdata` equals `dram_rdata` and `dram_we` equals `cpu_we`. `in_range` is 1 exactly when `phys_addr[23:14]` is less than `mem_pages`.
- R10: `shadow_grant` equals `shadow_req` while there is no hit, and is 0 on a hit.
- R11: A register write taken at a rising clock edge changes the outputs only after that edge. While `cfg_we` is low, the held register values do not change.
- R12: Writes to register indices other than 3, 4 to 11 and 12 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index being written |
| cfg_wdata | input | 8 | Register write data |
| cpu_addr | input | 24 | CPU byte address |
| cpu_we | input | 1 | CPU write request |
| mem_pages | input | 11 | Installed memory size in 16 KB pages |
| dram_rdata | input | 8 | Read data returned by DRAM |
| shadow_req | input | 1 | Shadow-RAM decoder claims the current address |
| win_hit | output | 1 | Address falls inside an enabled window |
| phys_addr | output | 24 | Address to present to DRAM |
| in_range | output | 1 | Physical page lies below the installed size |
| dram_we | output | 1 | Write enable passed to DRAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| shadow_grant | output | 1 | Shadow decoding allowed for this address |

## Verification
All address-path results are combinational. The bench changes `cpu_addr` on a falling edge and samples 1 ns later, well before the next rising edge. A register write is due only after the rising edge that takes it. The bench therefore checks the old behaviour in the same half-cycle as the write strobe and the new behaviour on the following falling edge. The frame sweeps step through the whole 0xA0000 to 0xFFFFF region for every base, and each probe is compared with an address computed arithmetically in the bench.

// File: rtl/ems_pkg.sv
package ems_pkg;
  localparam int EMS_AW      = 24;
  localparam int EMS_PF_W    = 5;
  localparam int EMS_WIN_SH  = 14;
  localparam int EMS_N_WIN   = 4;
  localparam int EMS_DW      = 8;
  localparam int EMS_IDX_W   = 4;

  localparam int REG_CTRL    = 3;
  localparam int REG_PG0     = 4;
  localparam int REG_SEL     = 12;
  localparam int CTRL_EN_BIT = 3;

  localparam int UPPER_HI_W  = EMS_AW - 20;

  function automatic logic [EMS_AW-1:0] frame_base(input logic [1:0] sel);
    case (sel)
      2'd0:    frame_base = 24'h0C_0000;
      2'd1:    frame_base = 24'h0C_8000;
      2'd2:    frame_base = 24'h0D_0000;
      default: frame_base = 24'h0E_0000;
    endcase
  endfunction

  function automatic logic [2*EMS_PF_W-1:0] page_join(input logic [EMS_PF_W-1:0] hi,
                                                       input logic [EMS_PF_W-1:0] lo);
    page_join = {hi, lo};
  endfunction
endpackage

// File: rtl/ems_cfg_regs.sv
module ems_cfg_regs
  import ems_pkg::*;
#(
  parameter int N_WIN = EMS_N_WIN,
  parameter int PF_W  = EMS_PF_W,
  parameter int IDX_W = EMS_IDX_W,
  parameter int DW    = EMS_DW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DW-1:0]              wdata,
  output logic                       en,
  output logic [1:0]                 sel,
  output logic [N_WIN-1:0][PF_W-1:0] pg_hi,
  output logic [N_WIN-1:0][PF_W-1:0] pg_lo
);
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(REG_CTRL);
  localparam logic [IDX_W-1:0] SEL_IDX  = IDX_W'(REG_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= 1'b0;
      sel <= 2'd0;
    end else if (we) begin
      if (idx == CTRL_IDX) en  <= wdata[CTRL_EN_BIT];
      if (idx == SEL_IDX)  sel <= wdata[1:0];
    end
  end

  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(REG_PG0 + 2 * k);
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(REG_PG0 + 2 * k + 1);
    logic [PF_W-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (we) begin
        if (idx == HI_IDX) hi_q <= wdata[PF_W-1:0];
        if (idx == LO_IDX) lo_q <= wdata[PF_W-1:0];
      end
    end

    assign pg_hi[k] = hi_q;
    assign pg_lo[k] = lo_q;
  end
endmodule

// File: rtl/ems_win_match.sv
module ems_win_match
  import ems_pkg::*;
#(
  parameter int N_WIN  = EMS_N_WIN,
  parameter int PF_W   = EMS_PF_W,
  parameter int WIN_SH = EMS_WIN_SH,
  parameter int AW     = EMS_AW
) (
  input  logic                       en,
  input  logic [1:0]                 sel,
  input  logic [N_WIN-1:0][PF_W-1:0] pg_hi,
  input  logic [N_WIN-1:0][PF_W-1:0] pg_lo,
  input  logic [AW-1:0]              cpu_addr,
  output logic                       hit,
  output logic [AW-1:0]              phys
);
  localparam int            IDX_W = $clog2(N_WIN);
  localparam logic [AW-1:0] SPAN  = AW'(N_WIN) << WIN_SH;

  logic [AW-1:0]    base, rel;
  logic             below_1m, above_base, in_frame;
  logic [IDX_W-1:0] widx;

  assign base       = frame_base(sel);
  assign rel        = cpu_addr - base;
  assign below_1m   = (cpu_addr[AW-1:20] == '0);
  assign above_base = (cpu_addr >= base);
  assign in_frame   = (rel < SPAN);
  assign widx       = rel[WIN_SH +: IDX_W];
  assign hit        = en & below_1m & above_base & in_frame;

  always_comb begin
    if (hit) phys = {page_join(pg_hi[widx], pg_lo[widx]), cpu_addr[WIN_SH-1:0]};
    else     phys = cpu_addr;
  end
endmodule

// File: rtl/ems_mem_guard.sv
module ems_mem_guard
  import ems_pkg::*;
#(
  parameter int AW     = EMS_AW,
  parameter int WIN_SH = EMS_WIN_SH,
  parameter int DW     = EMS_DW,
  parameter int MP_W   = AW - WIN_SH + 1
) (
  input  logic            hit,
  input  logic [AW-1:0]   phys,
  input  logic [MP_W-1:0] mem_pages,
  input  logic            cpu_we,
  input  logic [DW-1:0]   dram_rdata,
  input  logic            shadow_req,
  output logic            in_range,
  output logic            dram_we,
  output logic [DW-1:0]   cpu_rdata,
  output logic            shadow_grant
);
  logic absent;

  assign in_range     = ({1'b0, phys[AW-1:WIN_SH]} < mem_pages);
  assign absent       = hit & ~in_range;
  assign dram_we      = cpu_we & ~absent;
  assign cpu_rdata    = absent ? '1 : dram_rdata;
  assign shadow_grant = shadow_req & ~hit;
endmodule

// File: rtl/ems_xlate.sv
module ems_xlate
  import ems_pkg::*;
#(
  parameter int N_WIN  = EMS_N_WIN,
  parameter int PF_W   = EMS_PF_W,
  parameter int WIN_SH = EMS_WIN_SH,
  parameter int AW     = EMS_AW,
  parameter int DW     = EMS_DW,
  parameter int IDX_W  = EMS_IDX_W,
  parameter int MP_W   = AW - WIN_SH + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [AW-1:0]   cpu_addr,
  input  logic            cpu_we,
  input  logic [MP_W-1:0] mem_pages,
  input  logic [DW-1:0]   dram_rdata,
  input  logic            shadow_req,
  output logic            win_hit,
  output logic [AW-1:0]   phys_addr,
  output logic            in_range,
  output logic            dram_we,
  output logic [DW-1:0]   cpu_rdata,
  output logic            shadow_grant
);
  logic                       xl_en;
  logic [1:0]                 xl_sel;
  logic [N_WIN-1:0][PF_W-1:0] pg_hi, pg_lo;

  ems_cfg_regs #(.N_WIN(N_WIN), .PF_W(PF_W), .IDX_W(IDX_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .en(xl_en), .sel(xl_sel), .pg_hi(pg_hi), .pg_lo(pg_lo)
  );

  ems_win_match #(.N_WIN(N_WIN), .PF_W(PF_W), .WIN_SH(WIN_SH), .AW(AW)) u_match (
    .en(xl_en), .sel(xl_sel), .pg_hi(pg_hi), .pg_lo(pg_lo),
    .cpu_addr(cpu_addr), .hit(win_hit), .phys(phys_addr)
  );

  ems_mem_guard #(.AW(AW), .WIN_SH(WIN_SH), .DW(DW), .MP_W(MP_W)) u_guard (
    .hit(win_hit), .phys(phys_addr), .mem_pages(mem_pages), .cpu_we(cpu_we),
    .dram_rdata(dram_rdata), .shadow_req(shadow_req), .in_range(in_range),
    .dram_we(dram_we), .cpu_rdata(cpu_rdata), .shadow_grant(shadow_grant)
  );
endmodule

// File: rtl/ems_xlate_chk.sv
module ems_xlate_chk #(
  parameter int N_WIN  = 4,
  parameter int PF_W   = 5,
  parameter int WIN_SH = 14,
  parameter int AW     = 24,
  parameter int DW     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [AW-1:0]         cpu_addr,
  input logic                  cpu_we,
  input logic                  win_hit,
  input logic [AW-1:0]         phys_addr,
  input logic                  in_range,
  input logic                  dram_we,
  input logic [DW-1:0]         cpu_rdata,
  input logic                  shadow_req,
  input logic                  shadow_grant,
  input logic                  xl_en,
  input logic [N_WIN*PF_W-1:0] pg_hi,
  input logic [N_WIN*PF_W-1:0] pg_lo
);
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> xl_en); // R2
  AST_HIT_BELOW_1M: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (cpu_addr[AW-1:20] == '0)); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (phys_addr[WIN_SH-1:0] == cpu_addr[WIN_SH-1:0])); // R6
  AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (phys_addr == cpu_addr)); // R7
  AST_ABSENT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !in_range) |-> (!dram_we && (cpu_rdata == '1))); // R8
  AST_PRESENT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_hit || in_range) |-> (dram_we == cpu_we)); // R9
  AST_SHADOW_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> !shadow_grant); // R10
  AST_SHADOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (shadow_grant == shadow_req)); // R10
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(pg_hi) && $stable(pg_lo) && $stable(xl_en))); // R11
endmodule

bind ems_xlate ems_xlate_chk #(
  .N_WIN(N_WIN), .PF_W(PF_W), .WIN_SH(WIN_SH), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .win_hit(win_hit), .phys_addr(phys_addr), .in_range(in_range), .dram_we(dram_we),
  .cpu_rdata(cpu_rdata), .shadow_req(shadow_req), .shadow_grant(shadow_grant),
  .xl_en(xl_en), .pg_hi(pg_hi), .pg_lo(pg_lo)
);

// File: tb/ems_xlate_tb_top.sv
module ems_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [10:0] mem_pages = 11'd256;
  logic [7:0]  dram_rdata = 8'h5A;
  logic        shadow_req = 1'b0;
  logic        win_hit, in_range, dram_we, shadow_grant;
  logic [23:0] phys_addr;
  logic [7:0]  cpu_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic       m_en;
  logic [1:0] m_sel;
  logic [4:0] m_hi [4];
  logic [4:0] m_lo [4];

  always #5 clk = ~clk;

  ems_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .mem_pages(mem_pages), .dram_rdata(dram_rdata),
    .shadow_req(shadow_req), .win_hit(win_hit), .phys_addr(phys_addr), .in_range(in_range),
    .dram_we(dram_we), .cpu_rdata(cpu_rdata), .shadow_grant(shadow_grant)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] base_of(input logic [1:0] s);
    return 24'hC0000 + ((s == 2'd3) ? 24'h20000 : 24'(s) * 24'h8000);
  endfunction

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [23:0] a, input string req);
    logic [23:0] b, e_phys;
    logic        e_hit, e_absent;
    int          w;
    cpu_addr = a;
    #1;
    b = base_of(m_sel);
    e_hit = m_en && (a < 24'h100000) && (a >= b) && (a < b + 24'h10000);
    w = int'((a - b) >> 14);
    e_phys = e_hit ? ((24'(m_hi[w & 3]) << 19) | (24'(m_lo[w & 3]) << 14) | (a & 24'h3FFF)) : a;
    e_absent = e_hit && ((e_phys >> 14) >= 24'(mem_pages));
    chk(win_hit == e_hit, {req, " hit"}, 32'(win_hit), 32'(e_hit));
    chk(phys_addr == e_phys, {req, " phys"}, 32'(phys_addr), 32'(e_phys));
    chk(dram_we == (cpu_we && !e_absent), {req, " R8/R9 we"}, 32'(dram_we), 32'(cpu_we && !e_absent));
    chk(cpu_rdata == (e_absent ? 8'hFF : dram_rdata), {req, " R8/R9 rdata"}, 32'(cpu_rdata),
        32'(e_absent ? 8'hFF : dram_rdata));
    chk(shadow_grant == (shadow_req && !e_hit), {req, " R10 shadow"}, 32'(shadow_grant),
        32'(shadow_req && !e_hit));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_sel = 0;
    for (int k = 0; k < 4; k++) begin m_hi[k] = 0; m_lo[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, nothing hits
    probe(24'h0C1234, "R1 reset");
    probe(24'h0E0000, "R1 reset");

    // R5: page fields, junk in bits 7:5; window 1 at page 255, window 2 at page 256
    wr(4'd4, 8'hE0); m_hi[0] = 5'd0;  wr(4'd5, 8'hA3); m_lo[0] = 5'd3;
    wr(4'd6, 8'h67); m_hi[1] = 5'd7;  wr(4'd7, 8'hFF); m_lo[1] = 5'd31;
    wr(4'd8, 8'h28); m_hi[2] = 5'd8;  wr(4'd9, 8'hC0); m_lo[2] = 5'd0;
    wr(4'd10, 8'h1F); m_hi[3] = 5'd31; wr(4'd11, 8'h51); m_lo[3] = 5'd17;
    probe(24'h0C0000, "R2 disabled");

    // R11: enable takes effect only after the capturing edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd3; cfg_wdata = 8'h08; cpu_addr = 24'h0C0010;
    #1;
    chk(win_hit == 1'b0, "R11 before edge", 32'(win_hit), 0);
    @(negedge clk);
    cfg_we = 1'b0; m_en = 1;
    #1;
    chk(win_hit == 1'b1, "R11 after edge", 32'(win_hit), 1);

    // R3 R4 R5 R6 R7 R8 R9 R10: sweep every base across the upper area
    shadow_req = 1'b1;
    for (int s = 0; s < 4; s++) begin
      wr(4'd12, 8'hFC | 8'(s)); m_sel = 2'(s);
      for (int a = 24'hA0000; a < 24'h100000; a += 24'h800) begin
        cpu_we = a[11];
        probe(24'(a) + 24'h123, "R3 R6 R7 sweep");
      end
      probe(base_of(m_sel) - 24'd1, "R4 below base");
      probe(base_of(m_sel), "R4 base");
      probe(base_of(m_sel) + 24'hFFFF, "R4 last byte");
      probe(base_of(m_sel) + 24'h10000, "R4 past frame");
      probe(base_of(m_sel) + 24'h100000, "R4 above 1M");
    end

    // R8: window 1 (page 255) present, window 2 (page 256) absent
    cpu_we = 1'b1;
    probe(24'h0E4ABC, "R9 page 255");
    chk(in_range == 1'b1, "R9 in_range", 32'(in_range), 1);
    probe(24'h0E8ABC, "R8 page 256");
    chk(in_range == 1'b0, "R8 in_range", 32'(in_range), 0);
    mem_pages = 11'd257;
    probe(24'h0E8ABC, "R9 page 256 grown");

    // R12: unused indices leave outputs alone
    wr(4'd0, 8'hFF); wr(4'd2, 8'h00); wr(4'd13, 8'hFF); wr(4'd15, 8'h00);
    probe(24'h0E8ABC, "R12 unused idx");
    probe(24'h0EC001, "R12 unused idx");

    // R2: disable with other bits set
    wr(4'd3, 8'hF7); m_en = 0;
    probe(24'h0E4000, "R2 disable");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule